// File: doc/BRIEF.md
# Toggle-Polled Flash Bank Sequencer

This block erases and programs one bank of a byte-wide parallel flash device. The device accepts commands only after a fixed two-write unlock handshake. The block does not read a status register. It decides that an internal operation has finished when two back-to-back reads of the bank base return the same byte, because the device toggles a data bit while it is busy. A user raises a start strobe for erase or for program and supplies the bank base address. For programming, the block fetches each source byte through a combinational read port indexed by the byte's position in the bank.

Every operation ends with a reset command to the base address. After that the block reads the whole bank back and compares it: every byte must be 0xFF after an erase, and every byte must match the source after a program. The result is reported on two flags, one for a poll that never settled and one for a readback mismatch. The spacing between command writes, the poll limit and the bank size are parameters, so one netlist can serve different device speeds and bank sizes.

Top module: `flseq_ctrl`

## Requirements
- R1: After reset, busy, done, timeout and verify_err are low, and no flash write or read strobe is asserted.
- R2: Every erase and every per-byte program sequence opens with 0xAA written to base+0x555 and then 0x55 written to base+0x2AA.
- R3: An erase issues exactly six command writes. These are the unlock pair, 0x80 to base+0x555, a second unlock pair, and 0x30 to the base.
- R4: Programming issues four writes per byte, walking the byte index upward from 0. The four writes are the unlock pair, 0xA0 to base+0x555, and the source byte to base+index.
- R5: Any two flash write strobes are at least GAP_CYC clock cycles apart.
- R6: Completion polling reads the base address twice on consecutive cycles, with no write in between. The poll ends when the two bytes are equal.
- R7: After MAX_POLL unequal read pairs, timeout is set. In a program, this abandons all remaining bytes.
- R8: Every operation, including one that timed out, issues 0xF0 to the base address as its final command write.
- R9: After the reset write, every bank byte is read back. The expected value is 0xFF after an erase and the source byte after a program. Any difference sets verify_err.
- R10: busy is high from the cycle after an accepted start until done. done is a single-cycle pulse with busy low. timeout and verify_err hold their values until the next accepted start clears them.
- R11: Start strobes are ignored while busy. If start_erase and start_prog arrive together, the erase is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_erase | input | 1 | Request a bank erase |
| start_prog | input | 1 | Request a bank program |
| bank_base | input | ADDR_W | Flash address of the bank's first byte, captured at start |
| src_addr | output | IDX_W | Index of the source byte wanted |
| src_data | input | 8 | Source byte at src_addr, same cycle |
| fl_addr | output | ADDR_W | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe, one cycle per write |
| fl_re | output | 1 | Flash read strobe; data returns on fl_rdata the next cycle |
| fl_rdata | input | 8 | Flash read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | A completion poll ran out of attempts |
| verify_err | output | 1 | Readback differed from the expected contents |

## Verification
Erase is run on a bank that holds zeros, on a bank with one stuck byte, and on a device that never stops toggling. Between them these separate a clean result, a readback mismatch, and a poll timeout. Program is run with two different source patterns over an erased bank. It is also run over a bank that was programmed before and not erased, where only the verify can catch the AND-ed contents, and once with a device that stays busy on the first byte, which shows that the remaining bytes are abandoned. A flash model follows every command write and flags any step that breaks the unlock, command or byte order. A separate base address and a start issued mid-operation check the offset arithmetic and that a start is ignored while busy.

// File: rtl/flseq_pkg.sv
package flseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_GAP, ST_POLL, ST_RST, ST_RGAP, ST_VRD, ST_VCMP, ST_DONE
  } seq_st_t;

  typedef enum logic [1:0] { OFS_K1, OFS_K2, OFS_BASE, OFS_TGT } ofs_sel_t;

  localparam logic [7:0] BYTE_KEY1   = 8'hAA;
  localparam logic [7:0] BYTE_KEY2   = 8'h55;
  localparam logic [7:0] BYTE_ERASE  = 8'h80;
  localparam logic [7:0] BYTE_SECTOR = 8'h30;
  localparam logic [7:0] BYTE_PROG   = 8'hA0;
  localparam logic [7:0] BYTE_RESET  = 8'hF0;
  localparam logic [11:0] OFFS_K1    = 12'h555;
  localparam logic [11:0] OFFS_K2    = 12'h2AA;

  function automatic logic [2:0] last_step(input logic is_erase);
    return is_erase ? 3'd5 : 3'd3;
  endfunction

  function automatic ofs_sel_t step_ofs(input logic is_erase, input logic [2:0] step);
    case (step)
      3'd0, 3'd2: return OFS_K1;
      3'd1, 3'd4: return OFS_K2;
      3'd3:       return is_erase ? OFS_K1 : OFS_TGT;
      default:    return OFS_BASE;
    endcase
  endfunction

  function automatic logic [7:0] step_data(input logic is_erase, input logic [2:0] step,
                                           input logic [7:0] pbyte);
    case (step)
      3'd0:    return BYTE_KEY1;
      3'd1:    return BYTE_KEY2;
      3'd2:    return is_erase ? BYTE_ERASE : BYTE_PROG;
      3'd3:    return is_erase ? BYTE_KEY1 : pbyte;
      3'd4:    return BYTE_KEY2;
      default: return BYTE_SECTOR;
    endcase
  endfunction

endpackage

// File: rtl/flseq_gap_timer.sv
module flseq_gap_timer #(
  parameter int GAP_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic expire
);
  localparam int CW = $clog2(GAP_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (kick)          cnt_q <= CW'(GAP_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == CW'(1));
endmodule

// File: rtl/flseq_toggle_poll.sv
module flseq_toggle_poll #(
  parameter int MAX_POLL = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] rdata,
  output logic       rd_req,
  output logic       rd_first,
  output logic       settled,
  output logic       gave_up
);
  localparam int CW = $clog2(MAX_POLL + 1);
  typedef enum logic [1:0] { PL_IDLE, PL_RD1, PL_RD2, PL_CMP } pl_st_t;

  pl_st_t        st_q;
  logic [CW-1:0] tries_q;
  logic [7:0]    first_q;
  logic          same;

  assign same     = (rdata == first_q);
  assign rd_first = (st_q == PL_RD1);
  assign rd_req   = (st_q == PL_RD1) || (st_q == PL_RD2);
  assign settled  = (st_q == PL_CMP) && same;
  assign gave_up  = (st_q == PL_CMP) && !same && (tries_q == CW'(MAX_POLL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PL_IDLE;
      tries_q <= '0;
      first_q <= '0;
    end else begin
      case (st_q)
        PL_IDLE: if (go) begin st_q <= PL_RD1; tries_q <= '0; end
        PL_RD1:  st_q <= PL_RD2;
        PL_RD2:  begin first_q <= rdata; st_q <= PL_CMP; end
        default: begin
          if (settled || gave_up) st_q <= PL_IDLE;
          else begin
            tries_q <= tries_q + 1'b1;
            st_q    <= PL_RD1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/flseq_ctrl.sv
module flseq_ctrl
  import flseq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int BANK_BYTES = 8192,
  parameter int GAP_CYC    = 250,
  parameter int MAX_POLL   = 1000000,
  localparam int IDX_W     = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_erase,
  input  logic              start_prog,
  input  logic [ADDR_W-1:0] bank_base,
  output logic [IDX_W-1:0]  src_addr,
  input  logic [7:0]        src_data,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  output logic              fl_we,
  output logic              fl_re,
  input  logic [7:0]        fl_rdata,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic              verify_err
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BANK_BYTES - 1);

  seq_st_t           state_q;
  logic              erase_q;
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;
  logic [2:0]        step_q;
  logic              start_acc;
  logic              gap_exp;
  logic              poll_go, poll_rd, poll_first, poll_settled, poll_gaveup;
  logic              last_cmd;
  logic [7:0]        expect_byte;
  ofs_sel_t          ofs;

  assign start_acc   = ((state_q == ST_IDLE) || (state_q == ST_DONE)) && (start_erase || start_prog);
  assign last_cmd    = (step_q == last_step(erase_q));
  assign poll_go     = (state_q == ST_GAP) && gap_exp && last_cmd;
  assign src_addr    = idx_q;
  assign expect_byte = erase_q ? 8'hFF : src_data;
  assign ofs         = step_ofs(erase_q, step_q);

  flseq_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .kick(fl_we), .expire(gap_exp)
  );

  flseq_toggle_poll #(.MAX_POLL(MAX_POLL)) u_poll (
    .clk(clk), .rst_n(rst_n), .go(poll_go), .rdata(fl_rdata),
    .rd_req(poll_rd), .rd_first(poll_first), .settled(poll_settled), .gave_up(poll_gaveup)
  );

  always_comb begin
    fl_we    = (state_q == ST_CMD) || (state_q == ST_RST);
    fl_re    = poll_rd || (state_q == ST_VRD);
    fl_wdata = (state_q == ST_RST) ? BYTE_RESET : step_data(erase_q, step_q, src_data);
    fl_addr  = base_q;
    if (state_q == ST_VRD) fl_addr = base_q + ADDR_W'(idx_q);
    else if (state_q == ST_CMD) begin
      case (ofs)
        OFS_K1:  fl_addr = base_q + ADDR_W'(OFFS_K1);
        OFS_K2:  fl_addr = base_q + ADDR_W'(OFFS_K2);
        OFS_TGT: fl_addr = base_q + ADDR_W'(idx_q);
        default: fl_addr = base_q;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done = (state_q == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      erase_q    <= 1'b0;
      base_q     <= '0;
      idx_q      <= '0;
      step_q     <= '0;
      timeout    <= 1'b0;
      verify_err <= 1'b0;
    end else if (start_acc) begin
      state_q    <= ST_CMD;
      erase_q    <= start_erase;
      base_q     <= bank_base;
      idx_q      <= '0;
      step_q     <= '0;
      timeout    <= 1'b0;
      verify_err <= 1'b0;
    end else begin
      case (state_q)
        ST_CMD:  state_q <= ST_GAP;
        ST_GAP:  if (gap_exp) begin
                   if (last_cmd) state_q <= ST_POLL;
                   else begin step_q <= step_q + 1'b1; state_q <= ST_CMD; end
                 end
        ST_POLL: if (poll_gaveup) begin
                   timeout <= 1'b1;
                   state_q <= ST_RST;
                 end else if (poll_settled) begin
                   if (erase_q || idx_q == LAST_IDX) state_q <= ST_RST;
                   else begin
                     idx_q   <= idx_q + 1'b1;
                     step_q  <= '0;
                     state_q <= ST_CMD;
                   end
                 end
        ST_RST:  state_q <= ST_RGAP;
        ST_RGAP: if (gap_exp) begin idx_q <= '0; state_q <= ST_VRD; end
        ST_VRD:  state_q <= ST_VCMP;
        ST_VCMP: begin
                   if (fl_rdata != expect_byte) verify_err <= 1'b1;
                   if (idx_q == LAST_IDX) state_q <= ST_DONE;
                   else begin idx_q <= idx_q + 1'b1; state_q <= ST_VRD; end
                 end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flseq_ctrl_chk.sv
module flseq_ctrl_chk #(
  parameter int ADDR_W  = 16,
  parameter int GAP_CYC = 250
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_acc,
  input logic              poll_first,
  input logic              poll_gaveup,
  input logic [ADDR_W-1:0] base_q,
  input logic [ADDR_W-1:0] fl_addr,
  input logic [7:0]        fl_wdata,
  input logic              fl_we,
  input logic              fl_re,
  input logic              busy,
  input logic              done
);
  localparam int SW = $clog2(GAP_CYC + 1);
  logic [SW-1:0] since_q;
  logic          fresh_q, pend_rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q    <= SW'(GAP_CYC);
      fresh_q    <= 1'b0;
      pend_rst_q <= 1'b0;
    end else begin
      if (fl_we) since_q <= '0;
      else if (since_q < SW'(GAP_CYC)) since_q <= since_q + 1'b1;
      if (start_acc) fresh_q <= 1'b1;
      else if (fl_we) fresh_q <= 1'b0;
      if (poll_gaveup) pend_rst_q <= 1'b1;
      else if (fl_we) pend_rst_q <= 1'b0;
    end
  end

  AST_WRITE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |-> since_q >= SW'(GAP_CYC)); // R5
  AST_UNLOCK_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && fresh_q) |-> (fl_wdata == 8'hAA && fl_addr == base_q + ADDR_W'(12'h555))); // R2
  AST_POLL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    poll_first |=> (fl_re && !fl_we && fl_addr == base_q)); // R6
  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re)); // R6
  AST_TIMEOUT_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && pend_rst_q) |-> (fl_wdata == 8'hF0 && fl_addr == base_q)); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fl_we && !fl_re)); // R10
endmodule

bind flseq_ctrl flseq_ctrl_chk #(.ADDR_W(ADDR_W), .GAP_CYC(GAP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .poll_first(poll_first),
  .poll_gaveup(poll_gaveup), .base_q(base_q), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
  .fl_we(fl_we), .fl_re(fl_re), .busy(busy), .done(done)
);

// File: tb/flseq_ctrl_tb.sv
module flseq_ctrl_tb;
  localparam int AW = 16, NB = 16, GAP = 3, MAXP = 8, IW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_erase = 1'b0, start_prog = 1'b0;
  logic [AW-1:0] bank_base = 16'h4000;
  logic [IW-1:0] src_addr;
  logic [7:0] src_data, fl_wdata, fl_rdata;
  logic [AW-1:0] fl_addr;
  logic fl_we, fl_re, busy, done, timeout, verify_err;

  always #2 clk = ~clk;

  flseq_ctrl #(.ADDR_W(AW), .BANK_BYTES(NB), .GAP_CYC(GAP), .MAX_POLL(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_erase(start_erase), .start_prog(start_prog),
    .bank_base(bank_base), .src_addr(src_addr), .src_data(src_data),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
    .fl_rdata(fl_rdata), .busy(busy), .done(done), .timeout(timeout), .verify_err(verify_err)
  );

  // source memory and flash model
  logic [7:0] src_mem [NB];
  assign src_data = src_mem[src_addr];

  logic [7:0] fmem [NB];
  logic [AW-1:0] mbase = 16'h4000;
  int erase_polls = 3, prog_polls = 1, stuck_idx = -1;
  int wr_count = 0, seq_err = 0, busy_rd = 0, mst = 0, pnext = 0;
  logic tog = 1'b0;
  logic [AW-1:0] last_wa;
  logic [7:0] last_wd;

  always @(posedge clk) begin
    logic [AW-1:0] off;
    off = fl_addr - mbase;
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) fmem[i] <= 8'h00;
      fl_rdata <= 8'h00;
    end else begin
      if (fl_we) begin
        wr_count <= wr_count + 1;
        last_wa  <= fl_addr;
        last_wd  <= fl_wdata;
        if (fl_wdata == 8'hF0 && off == 0) begin
          mst <= 0; busy_rd <= 0; pnext <= 0;
        end else begin
          case (mst)
            0: if (off == 16'h555 && fl_wdata == 8'hAA) mst <= 1; else seq_err <= seq_err + 1;
            1: if (off == 16'h2AA && fl_wdata == 8'h55) mst <= 2; else seq_err <= seq_err + 1;
            2: if (off == 16'h555 && fl_wdata == 8'h80) mst <= 3;
               else if (off == 16'h555 && fl_wdata == 8'hA0) mst <= 6;
               else seq_err <= seq_err + 1;
            3: if (off == 16'h555 && fl_wdata == 8'hAA) mst <= 4; else seq_err <= seq_err + 1;
            4: if (off == 16'h2AA && fl_wdata == 8'h55) mst <= 5; else seq_err <= seq_err + 1;
            5: if (off == 0 && fl_wdata == 8'h30) begin
                 for (int i = 0; i < NB; i++) fmem[i] <= (i == stuck_idx) ? 8'h12 : 8'hFF;
                 busy_rd <= erase_polls; mst <= 0;
               end else seq_err <= seq_err + 1;
            6: if (int'(off) == pnext) begin
                 fmem[off[IW-1:0]] <= fmem[off[IW-1:0]] & fl_wdata;
                 busy_rd <= prog_polls; mst <= 0; pnext <= pnext + 1;
               end else seq_err <= seq_err + 1;
            default: seq_err <= seq_err + 1;
          endcase
        end
      end
      if (fl_re) begin
        if (busy_rd > 0) begin
          fl_rdata <= tog ? 8'h44 : 8'h04;
          tog <= ~tog;
          busy_rd <= busy_rd - 1;
        end else fl_rdata <= (off < NB) ? fmem[off[IW-1:0]] : 8'hFF;
      end
    end
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Issue a start and wait for done; returns writes seen
  task automatic run_op(input bit erase, output int writes);
    int w0, guard;
    bit seen;
    w0 = wr_count;
    @(negedge clk);
    start_erase = erase; start_prog = !erase;
    @(negedge clk);
    start_erase = 0; start_prog = 0;
    chk(busy == 1'b1, "R10 busy after start", busy, 1);
    seen = 0;
    for (guard = 0; guard < 20000 && !seen; guard++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(seen, "R10 done reached", seen, 1);
    chk(busy == 1'b0, "R10 busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R10 done single cycle", done, 0);
    writes = wr_count - w0;
  endtask

  task automatic chk_common(input string tag);
    chk(seq_err == 0, {tag, " R2 R3 R4 command order"}, seq_err, 0);
    chk(last_wd == 8'hF0 && last_wa == mbase, {tag, " R8 final reset write"}, last_wd, 8'hF0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !timeout && !verify_err, "R1 reset flags",
        {busy, done, timeout, verify_err}, 0);
    chk(!fl_we && !fl_re, "R1 reset strobes", {fl_we, fl_re}, 0);
  endtask

  task automatic t_erase_clean();
    int w;
    run_op(1, w);
    chk(w == 7, "R3 erase write count", w, 7);
    chk_common("erase");
    chk(!timeout && !verify_err, "R9 erase clean", {timeout, verify_err}, 0);
    for (int i = 0; i < NB; i++) chk(fmem[i] == 8'hFF, "R3 bank erased", fmem[i], 8'hFF);
  endtask

  task automatic t_program(input int pat);
    int w;
    for (int i = 0; i < NB; i++) src_mem[i] = (pat == 0) ? (8'hA0 | 8'(i)) : ({4'(i), 4'hF});
    run_op(0, w);
    chk(w == 4 * NB + 1, "R4 program write count", w, 4 * NB + 1);
    chk_common("prog");
    chk(!timeout && !verify_err, "R9 program clean", {timeout, verify_err}, 0);
    for (int i = 0; i < NB; i++) chk(fmem[i] == src_mem[i], "R4 byte programmed", fmem[i], src_mem[i]);
  endtask

  task automatic t_erase_stuck();
    int w;
    stuck_idx = 5;
    run_op(1, w);
    stuck_idx = -1;
    chk(verify_err == 1'b1, "R9 erase readback mismatch", verify_err, 1);
    chk(timeout == 1'b0, "R9 no timeout on stuck byte", timeout, 0);
  endtask

  task automatic t_program_dirty();
    int w;
    t_erase_clean();
    t_program(1);
    for (int i = 0; i < NB; i++) src_mem[i] = 8'hA0 | 8'(i);
    run_op(0, w);
    chk(verify_err == 1'b1, "R9 program over unerased bank", verify_err, 1);
    chk_common("dirty");
  endtask

  task automatic t_erase_timeout();
    int w;
    erase_polls = 1000;
    run_op(1, w);
    erase_polls = 3;
    chk(timeout == 1'b1, "R7 erase timeout flag", timeout, 1);
    chk(w == 7, "R8 erase timeout writes", w, 7);
    chk_common("etmo");
    repeat (5) @(negedge clk);
    chk(timeout == 1'b1, "R10 timeout held", timeout, 1);
  endtask

  task automatic t_prog_timeout();
    int w;
    t_erase_clean();
    chk(timeout == 1'b0, "R10 flag cleared by new start", timeout, 0);
    for (int i = 0; i < NB; i++) src_mem[i] = 8'hA0 | 8'(i);
    prog_polls = 1000;
    run_op(0, w);
    prog_polls = 1;
    chk(timeout == 1'b1, "R7 program timeout flag", timeout, 1);
    chk(w == 5, "R7 remaining bytes abandoned", w, 5);
    chk_common("ptmo");
    chk(fmem[1] == 8'hFF, "R7 byte1 untouched", fmem[1], 8'hFF);
  endtask

  task automatic t_ignore_busy();
    int w0, w;
    bit seen;
    w0 = wr_count;
    @(negedge clk);
    start_erase = 1; start_prog = 1;
    @(negedge clk);
    start_erase = 0; start_prog = 0;
    repeat (10) @(negedge clk);
    start_prog = 1;
    @(negedge clk);
    start_prog = 0;
    seen = 0;
    for (int g = 0; g < 20000 && !seen; g++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    repeat (30) @(negedge clk);
    w = wr_count - w0;
    chk(w == 7, "R11 erase wins, mid-op start ignored", w, 7);
    chk(busy == 1'b0, "R11 no second operation", busy, 0);
    chk_common("ign");
  endtask

  task automatic t_other_base();
    bank_base = 16'h2300;
    mbase = 16'h2300;
    t_erase_clean();
    t_program(0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_erase_clean();
    t_program(0);
    t_erase_clean();
    t_program(1);
    t_erase_stuck();
    t_program_dirty();
    t_erase_timeout();
    t_prog_timeout();
    t_ignore_busy();
    t_other_base();
    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_up();
  end
endmodule